// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block times accesses for one channel of an external memory bus. A host loads a channel control word that holds a first-access wait, a page wait, a page-mode selector and a bus-width code. The host then issues single or burst transfers through a valid/ready request port. For each accepted transfer the block drives chip-select and a read or write strobe toward the memory. It steps the beat address and pulses a beat-done output as each beat completes. The number of cycles each beat lasts comes from the programmed waits.

There are two timing modes. In normal mode every beat waits a 6-bit count built from both wait fields. In page mode the first beat of each page waits the long first-access count, and the remaining beats of that page wait the short page count. Page size is 4, 8 or 16 beats. Pages are counted from the transfer's start beat. A transfer is given in 32-bit words, and the bus width converts that into a beat count. A transfer that arrives while the width code is the reserved value is refused with an error pulse.

The controller has four named states. ST_IDLE waits for a request. ST_FIRST times a beat with the first-access (or normal) wait. ST_PAGE times an in-page beat with the page wait. ST_REJECT issues the one-cycle error response. The transitions are:
- ST_IDLE to ST_FIRST on a request that is accepted.
- ST_IDLE to ST_REJECT on a request that is refused.
- ST_FIRST or ST_PAGE to ST_PAGE when a beat completes and the next beat lies inside the current page.
- ST_FIRST or ST_PAGE to ST_FIRST when a beat completes and the next beat opens a new page, or in normal mode.
- ST_FIRST or ST_PAGE to ST_IDLE when the last beat completes.
- ST_REJECT to ST_IDLE unconditionally.

Top module: `ebus_wait_seq`

## Requirements
- R1: The control word places the first wait in bits [3:0], the page wait in [5:4], the page mode in [7:6] and the bus width in [9:8]. It is written by `cfg_load`. After reset, a channel whose CH_ID is 0 or 7 holds first wait 15 and page wait 3. Every other channel holds zero waits. All channels reset to mode 00 and width 01.
- R2: `cfg_err` is high exactly when the page mode is not 00 and the first wait is less than or equal to the page wait.
- R3: With page mode 00, every beat uses the wait {page wait, first wait}, a 6-bit count from 0 to 63.
- R4: With page mode not 00, a page's first beat waits the first-wait value. Each later beat in the same page waits the page-wait value.
- R5: Page mode 01, 10 and 11 give pages of 4, 8 and 16 beats. The count starts at the transfer's first beat. After that many beats, the next beat is again a first access.
- R6: A beat with wait N holds its strobe for N+1 cycles. `beat_done` is high in the last of those cycles.
- R7: Width code 01 is 32-bit (1 beat per word), 10 is 16-bit (2 beats per word) and 11 is 8-bit (4 beats per word). A burst with word count W>0 moves W words. A single request, or a burst with W=0, moves one word.
- R8: A request accepted while the width code is 00 produces a one-cycle `req_err` in the next cycle. No chip-select or strobe is driven for it.
- R9: `bus_cs` is high from the cycle after acceptance until the final `beat_done`, and low in the next cycle. `bus_rd` is driven for `req_we`=0 and `bus_wr` for `req_we`=1.
- R10: `bus_addr` starts at the request address and rises by the beat size in bytes (4, 2 or 1) after each beat.
- R11: The control word is captured when a request is accepted. Writes made during a transfer do not change that transfer's timing.
- R12: `req_ready` is high only while idle, and the first strobe cycle is the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 10 | Control word value |
| cfg_err | output | 1 | Page wait not below first wait in page mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst of req_words words |
| req_words | input | WORDS_W | Burst length in 32-bit words |
| req_addr | input | ADDR_W | Start byte address |
| req_err | output | 1 | Request refused (reserved width) |
| bus_cs | output | 1 | Chip-select, active high |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | ADDR_W | Current beat address |
| beat_done | output | 1 | Beat completes this cycle |

## Verification
The bench builds the main instance with CH_ID=7, ADDR_W=16 and WORDS_W=6. With these values the boot-time 63-cycle wait can be exercised right after reset. Bursts of up to 63 words are also possible, so 8-bit transfers can cross several 4-, 8- and 16-beat pages. A second instance with CH_ID=2 covers the zero-wait reset variant. A scoreboard predicts the strobe length and address of every beat from the bench's own copy of the control word. It compares these predictions beat by beat and then checks that chip-select drops on time.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
    typedef struct packed {
        logic [1:0] bus_sz;
        logic [1:0] pmode;
        logic [1:0] pwt;
        logic [3:0] wt;
    } chan_cfg_t;

    localparam int CFG_W  = $bits(chan_cfg_t);
    localparam int WAIT_W = 6;
    localparam int PAGE_W = 5;

    localparam logic [1:0] BUS_RSVD  = 2'b00;
    localparam logic [1:0] BUS_W32   = 2'b01;
    localparam logic [1:0] BUS_W16   = 2'b10;
    localparam logic [1:0] BUS_W8    = 2'b11;
    localparam logic [1:0] PM_NORMAL = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_PAGE,
        ST_REJECT
    } seq_state_e;
endpackage

// File: rtl/ebus_cfg_reg.sv
module ebus_cfg_reg
    import ebus_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_wdata,
    output chan_cfg_t        cfg,
    output logic             cfg_err
);
    chan_cfg_t rst_val;

    // Boot channels start with the longest waits
    generate
        if (CH_ID == 0 || CH_ID == 7) begin : g_boot_chan
            assign rst_val = '{bus_sz: BUS_W32, pmode: PM_NORMAL, pwt: 2'b11, wt: 4'hF};
        end else begin : g_plain_chan
            assign rst_val = '{bus_sz: BUS_W32, pmode: PM_NORMAL, pwt: 2'b00, wt: 4'h0};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= rst_val;
        end else if (cfg_load) begin
            cfg <= chan_cfg_t'(cfg_wdata);
        end
    end

    assign cfg_err = (cfg.pmode != PM_NORMAL) && (cfg.wt <= {2'b00, cfg.pwt});
endmodule

// File: rtl/ebus_beat_plan.sv
module ebus_beat_plan
    import ebus_pkg::*;
#(
    parameter int WORDS_W = 6,
    localparam int BEAT_W = WORDS_W + 2
) (
    input  chan_cfg_t           cfg,
    input  logic                req_burst,
    input  logic [WORDS_W-1:0]  req_words,
    output logic [BEAT_W-1:0]   beats_total,
    output logic [2:0]          beat_bytes,
    output logic [WAIT_W-1:0]   first_wait,
    output logic [WAIT_W-1:0]   page_wait,
    output logic [PAGE_W-1:0]   page_beats,
    output logic                page_on,
    output logic                bus_bad
);
    logic [WORDS_W-1:0] words_eff;

    assign words_eff = (req_burst && req_words != '0) ? req_words : WORDS_W'(1);
    assign bus_bad   = (cfg.bus_sz == BUS_RSVD);
    assign page_on   = (cfg.pmode != PM_NORMAL);

    always_comb begin
        unique case (cfg.bus_sz)
            BUS_W16: begin
                beats_total = BEAT_W'(words_eff) << 1;
                beat_bytes  = 3'd2;
            end
            BUS_W8: begin
                beats_total = BEAT_W'(words_eff) << 2;
                beat_bytes  = 3'd1;
            end
            default: begin
                beats_total = BEAT_W'(words_eff);
                beat_bytes  = 3'd4;
            end
        endcase
    end

    always_comb begin
        unique case (cfg.pmode)
            2'b01:   page_beats = PAGE_W'(4);
            2'b10:   page_beats = PAGE_W'(8);
            default: page_beats = PAGE_W'(16);
        endcase
    end

    assign first_wait = page_on ? {2'b00, cfg.wt} : {cfg.pwt, cfg.wt};
    assign page_wait  = {4'b0000, cfg.pwt};
endmodule

// File: rtl/ebus_wait_ctr.sv
module ebus_wait_ctr
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              zero
);
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ebus_wait_seq.sv
module ebus_wait_seq
    import ebus_pkg::*;
#(
    parameter int CH_ID   = 0,
    parameter int ADDR_W  = 16,
    parameter int WORDS_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic               cfg_err,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic               req_burst,
    input  logic [WORDS_W-1:0] req_words,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_err,
    output logic               bus_cs,
    output logic               bus_rd,
    output logic               bus_wr,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               beat_done
);
    localparam int BEAT_W = WORDS_W + 2;

    chan_cfg_t          cfg;
    seq_state_e         state, nstate;

    logic [BEAT_W-1:0]  p_beats;
    logic [2:0]         p_bytes;
    logic [WAIT_W-1:0]  p_first, p_page;
    logic [PAGE_W-1:0]  p_pbeats;
    logic               p_pon, p_bus_bad;

    logic [BEAT_W-1:0]  beats_left;
    logic [PAGE_W-1:0]  page_pos;
    logic [ADDR_W-1:0]  cur_addr;
    logic               s_we, s_pon;
    logic [2:0]         s_bytes;
    logic [WAIT_W-1:0]  s_first, s_page;
    logic [PAGE_W-1:0]  s_pbeats;

    logic               accept, start_ok, in_beat, beat_end, last_beat, next_in_page;
    logic               ctr_load, ctr_zero;
    logic [WAIT_W-1:0]  ctr_val;

    ebus_cfg_reg #(.CH_ID(CH_ID)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .cfg_err   (cfg_err)
    );

    ebus_beat_plan #(.WORDS_W(WORDS_W)) u_plan (
        .cfg         (cfg),
        .req_burst   (req_burst),
        .req_words   (req_words),
        .beats_total (p_beats),
        .beat_bytes  (p_bytes),
        .first_wait  (p_first),
        .page_wait   (p_page),
        .page_beats  (p_pbeats),
        .page_on     (p_pon),
        .bus_bad     (p_bus_bad)
    );

    ebus_wait_ctr u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .run      (in_beat),
        .zero     (ctr_zero)
    );

    assign accept       = req_valid && (state == ST_IDLE);
    assign start_ok     = accept && !p_bus_bad;
    assign in_beat      = (state == ST_FIRST) || (state == ST_PAGE);
    assign beat_end     = in_beat && ctr_zero;
    assign last_beat    = (beats_left == '0);
    assign next_in_page = s_pon && ((page_pos + PAGE_W'(1)) != s_pbeats);
    assign ctr_load     = start_ok || (beat_end && !last_beat);
    assign ctr_val      = start_ok ? p_first : (next_in_page ? s_page : s_first);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) nstate = p_bus_bad ? ST_REJECT : ST_FIRST;
            end
            ST_FIRST, ST_PAGE: begin
                if (beat_end) begin
                    if (last_beat)         nstate = ST_IDLE;
                    else if (next_in_page) nstate = ST_PAGE;
                    else                   nstate = ST_FIRST;
                end
            end
            ST_REJECT: nstate = ST_IDLE;
        endcase
    end

    // Transfer context: captured at acceptance, stepped per beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_left <= '0;
            page_pos   <= '0;
            cur_addr   <= '0;
            s_we       <= 1'b0;
            s_pon      <= 1'b0;
            s_bytes    <= 3'd4;
            s_first    <= '0;
            s_page     <= '0;
            s_pbeats   <= PAGE_W'(16);
        end else if (start_ok) begin
            beats_left <= p_beats - BEAT_W'(1);
            page_pos   <= '0;
            cur_addr   <= req_addr;
            s_we       <= req_we;
            s_pon      <= p_pon;
            s_bytes    <= p_bytes;
            s_first    <= p_first;
            s_page     <= p_page;
            s_pbeats   <= p_pbeats;
        end else if (beat_end && !last_beat) begin
            beats_left <= beats_left - BEAT_W'(1);
            cur_addr   <= cur_addr + ADDR_W'(s_bytes);
            page_pos   <= next_in_page ? page_pos + PAGE_W'(1) : '0;
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        req_err   = 1'b0;
        bus_cs    = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        beat_done = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_FIRST, ST_PAGE: begin
                bus_cs    = 1'b1;
                bus_rd    = !s_we;
                bus_wr    = s_we;
                beat_done = ctr_zero;
            end
            ST_REJECT: req_err = 1'b1;
        endcase
    end

    assign bus_addr = cur_addr;
endmodule

// File: rtl/ebus_wait_seq_chk.sv
module ebus_wait_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              bus_bad,
    input logic              last_beat,
    input logic              cfg_load,
    input logic [9:0]        cfg_wdata,
    input logic              cfg_err,
    input logic              req_err,
    input logic              bus_cs,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              beat_done
);
    AST_REJECT_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && bus_bad |=> req_err && !bus_cs); // R8
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !bus_bad |=> bus_cs); // R12
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs && !beat_done |=> bus_cs); // R9
    AST_CS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done && last_beat |=> !bus_cs); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs && !beat_done |=> $stable(bus_addr)); // R10
    AST_CFG_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load && (cfg_wdata[7:6] != 2'b00) && (cfg_wdata[3:0] <= {2'b00, cfg_wdata[5:4]})
        |=> cfg_err); // R2
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_cs && !req_err); // R12
endmodule

bind ebus_wait_seq ebus_wait_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_bad   (p_bus_bad),
    .last_beat (last_beat),
    .cfg_load  (cfg_load),
    .cfg_wdata (cfg_wdata),
    .cfg_err   (cfg_err),
    .req_err   (req_err),
    .bus_cs    (bus_cs),
    .bus_addr  (bus_addr),
    .beat_done (beat_done)
);

// File: tb/tb_ebus_wait_seq.sv
module tb_ebus_wait_seq;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int ADDR_W  = 16;
    localparam int WORDS_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    logic               cfg_load = 1'b0;
    logic [9:0]         cfg_wdata = '0;
    logic               cfg_err;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic               req_we = 1'b0;
    logic               req_burst = 1'b0;
    logic [WORDS_W-1:0] req_words = '0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic               req_err;
    logic               bus_cs, bus_rd, bus_wr, beat_done;
    logic [ADDR_W-1:0]  bus_addr;

    logic               b_valid = 1'b0;
    logic               b_ready, b_err, b_cfg_err, b_cs, b_rd, b_wr, b_done;
    logic [ADDR_W-1:0]  b_addr;

    ebus_wait_seq #(.CH_ID(7), .ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_burst(req_burst),
        .req_words(req_words), .req_addr(req_addr), .req_err(req_err), .bus_cs(bus_cs),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .beat_done(beat_done)
    );

    ebus_wait_seq #(.CH_ID(2), .ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) dut_b (
        .clk(clk), .rst_n(rst_n), .cfg_load(1'b0), .cfg_wdata(10'd0), .cfg_err(b_cfg_err),
        .req_valid(b_valid), .req_ready(b_ready), .req_we(1'b0), .req_burst(1'b0),
        .req_words(6'd0), .req_addr(16'h0040), .req_err(b_err), .bus_cs(b_cs),
        .bus_rd(b_rd), .bus_wr(b_wr), .bus_addr(b_addr), .beat_done(b_done)
    );

    typedef struct {
        int          waitc;
        logic [15:0] addr;
        bit          we;
        bit          last;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;
    bit         strobe_bad = 1'b0;
    bit         drop_pending = 1'b0;
    bit         finished = 1'b0;
    logic [9:0] m_cfg = 10'b01_00_11_1111; // bench copy of the control word

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [9:0] v);
        @(posedge clk); #2;
        cfg_load  = 1'b1;
        cfg_wdata = v;
        @(posedge clk); #2;
        cfg_load  = 1'b0;
        m_cfg     = v;
    endtask

    // Driver: predict every beat, then hand the request to the design
    task automatic send_req(input bit we, input bit burst, input int words,
                            input logic [15:0] addr, input string tag);
        int bpb, nb, psz, w;
        logic [1:0] bs, pm;
        bs  = m_cfg[9:8];
        pm  = m_cfg[7:6];
        bpb = (bs == 2'b01) ? 4 : (bs == 2'b10) ? 2 : 1;
        nb  = ((burst && words != 0) ? words : 1) * (4 / bpb);
        psz = (pm == 2'b01) ? 4 : (pm == 2'b10) ? 8 : 16;
        if (bs != 2'b00) begin
            for (int i = 0; i < nb; i++) begin
                exp_t e;
                if (pm == 2'b00) w = int'({m_cfg[5:4], m_cfg[3:0]});
                else             w = ((i % psz) == 0) ? int'(m_cfg[3:0]) : int'(m_cfg[5:4]);
                e.waitc = w;
                e.addr  = addr + 16'(i * bpb);
                e.we    = we;
                e.last  = (i == nb - 1);
                e.tag   = tag;
                sb.push_back(e);
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        #1;
        req_valid = 1'b1;
        req_we    = we;
        req_burst = burst;
        req_words = WORDS_W'(words);
        req_addr  = addr;
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (sb.size() != 0 || bus_cs || drop_pending);
    endtask

    // Monitor: compare each completed beat against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (drop_pending) begin
                chk(!bus_cs, "R9 cs drop", int'(bus_cs), 0);
                chk(sb.size() == 0, "R7 beat count", sb.size(), 0);
                drop_pending = 1'b0;
            end
            if (bus_cs) begin
                cyc++;
                if (sb.size() > 0 && (bus_rd != !sb[0].we || bus_wr != sb[0].we)) strobe_bad = 1'b1;
            end
            if (beat_done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7 extra beat", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.waitc + 1, {e.tag, " strobe cycles"}, cyc, e.waitc + 1);
                    chk(bus_addr == e.addr, "R10 beat address", int'(bus_addr), int'(e.addr));
                    chk(!strobe_bad, "R9 strobe direction", int'(strobe_bad), 0);
                    if (e.last) drop_pending = 1'b1;
                end
                cyc = 0;
                strobe_bad = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R12 / R1 reset state
        chk(req_ready == 1'b1, "R12 ready after reset", int'(req_ready), 1);
        chk(bus_cs == 1'b0, "R9 cs after reset", int'(bus_cs), 0);
        chk(cfg_err == 1'b0, "R2 err after reset", int'(cfg_err), 0);
        chk(req_err == 1'b0, "R8 req_err after reset", int'(req_err), 0);

        // R1: boot channel defaults give 63 waits on a 32-bit bus
        send_req(1'b0, 1'b0, 0, 16'h1000, "R1");
        wait_idle();

        // R1: plain channel resets to zero waits
        @(negedge clk); #1 b_valid = 1'b1;
        @(posedge clk); #2 b_valid = 1'b0;
        @(negedge clk);
        chk(b_cs && b_done && b_rd, "R1 plain channel zero wait", int'(b_done), 1);
        @(negedge clk);
        chk(!b_cs, "R1 plain channel cs drop", int'(b_cs), 0);

        // R3 normal mode, 6-bit wait {2,5}=37, 32-bit write burst
        load_cfg(10'b01_00_10_0101);
        send_req(1'b1, 1'b1, 3, 16'h2000, "R3");
        wait_idle();

        // R6 zero wait, normal mode, 16-bit
        load_cfg(10'b10_00_00_0000);
        send_req(1'b0, 1'b1, 2, 16'h0100, "R6");
        wait_idle();

        // R4 / R5 page of 4, 16-bit, 10 beats
        load_cfg(10'b10_01_01_0110);
        chk(cfg_err == 1'b0, "R2 legal page setting", int'(cfg_err), 0);
        send_req(1'b0, 1'b1, 5, 16'h0302, "R4");
        wait_idle();

        // R5 page of 8, 8-bit, 12 beats
        load_cfg(10'b11_10_00_0011);
        send_req(1'b1, 1'b1, 3, 16'h0401, "R5");
        wait_idle();

        // R5 page of 16, 32-bit, 17 beats
        load_cfg(10'b01_11_01_0010);
        send_req(1'b0, 1'b1, 17, 16'h0800, "R5");
        wait_idle();

        // R7 single request ignores the word count
        load_cfg(10'b11_00_00_0001);
        send_req(1'b1, 1'b0, 5, 16'h0A00, "R7");
        wait_idle();

        // R2 configuration error flag
        load_cfg(10'b01_01_01_0001);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R2 wt equal pwt", int'(cfg_err), 1);
        load_cfg(10'b01_10_11_0000);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R2 wt below pwt", int'(cfg_err), 1);
        load_cfg(10'b01_00_11_0000);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R2 normal mode no error", int'(cfg_err), 0);

        // R8 reserved width code refused
        load_cfg(10'b00_00_00_0010);
        send_req(1'b0, 1'b1, 2, 16'h0C00, "R8");
        @(negedge clk);
        chk(req_err == 1'b1, "R8 error pulse", int'(req_err), 1);
        chk(!bus_cs && !bus_rd && !bus_wr, "R8 no strobes", int'(bus_cs), 0);
        @(negedge clk);
        chk(req_ready && !req_err && !bus_cs, "R8 back to idle", int'(req_ready), 1);

        // R11 control word captured at acceptance
        load_cfg(10'b01_00_00_0100);
        send_req(1'b0, 1'b1, 2, 16'h0E00, "R11");
        load_cfg(10'b11_01_00_1001);
        wait_idle();

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule